// File: doc/BRIEF.md
# NAND Word-Line Program Order Sequencer

This block walks one erase block of multi-level NAND cells through every program operation it needs, one command at a time. The order is interleaved rather than word-line by word-line. After its final step, a word-line n sees only one more neighbour operation: the final step of word-line n+1. The block can also issue a whole-block erase before the first program command.

A host pulses `start` with a cell density and a word-line count. The sequencer then offers commands over a valid/ready handshake. Each command carries a type, a word-line and a 0-based step index. The step index also names the logical page on that word-line. After each accepted command the sequencer waits for an internal timer to run out, and also for the external busy line to be low, before it offers the next command. A one-cycle `done` pulse marks the end of the job.

The ordering is a diagonal sweep. Step s of word-line w sits on diagonal d = w + s. Diagonals are taken in rising order, and inside a diagonal the steps are taken in rising order. Pairs whose word-line falls outside the block are left out.

Top module: `nand_wl_prog_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cmd_valid` and `done` are 0.
- R2: When the block is idle and `start` is sampled high with a legal word-line count, `cmd_valid` is 1 in the next cycle. With `erase_first` = 1 the first command is an erase (`cmd_type` = 0, `wl_index` = 0, `step_index` = 0). Otherwise the first command is a program (`cmd_type` = 1) of word-line 0, step 0.
- R3: Program commands follow the diagonal order. For each d from 0 to N+B-2, and each s from 0 to B-1 in rising order, the pair (wl = d-s, s) is issued when 0 <= d-s < N. N is the word-line count and B is the number of steps.
- R4: When `bits_per_cell` = 3, B is 3. Any other value gives B = 2.
- R5: With a word-line count of 1, the commands are word-line 0 with steps 0 to B-1 in order.
- R6: While `cmd_valid` = 1 and `cmd_ready` = 0, the command fields and `cmd_valid` stay unchanged.
- R7: With `flash_busy` low, `cmd_valid` (or `done` after the last command) returns exactly PROG_CYCLES cycles after a program command is accepted. After an erase is accepted it returns exactly ERASE_CYCLES cycles later.
- R8: The wait ends at the first clock edge at which the timer has run out and `flash_busy` is low. When busy is sampled high on edges 1..K after acceptance, the gap is max(T, K+1) cycles.
- R9: `done` is high for exactly one cycle, after the wait that follows the last command, and `cmd_valid` is 0 in that cycle.
- R10: `start` is ignored while a job is running. It is also ignored when the word-line count is 0 or above MAX_WL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job (sampled while idle) |
| bits_per_cell | input | 2 | Cell density; 3 selects three steps, anything else two |
| num_wordlines | input | WL_W+1 | Word-lines in the block, 1..MAX_WL |
| erase_first | input | 1 | Issue a block erase before programming |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken |
| cmd_type | output | 1 | 0 = erase, 1 = program |
| wl_index | output | WL_W | Target word-line |
| step_index | output | 2 | Program step / logical page, 0-based |
| flash_busy | input | 1 | Array still busy; holds the next command back |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The assertions assume three things about the inputs. `cmd_ready` may stall for any number of cycles. `flash_busy` may go high at any time, but it only matters during a wait. `start` may be pulsed at any time. The stimulus draws ready stalls of 0 to 3 cycles and busy bursts of up to 9 cycles, each starting right after an acceptance. Some jobs also carry a stray `start` in the middle, which must leave the stream intact. Configuration inputs are changed only while the block is idle, apart from those stray-start probes. The latched copy must then govern the running job.

// File: rtl/wlseq_pkg.sv
// Shared types for the word-line program order sequencer.
package wlseq_pkg;
    typedef enum logic {
        CMD_ERASE = 1'b0,
        CMD_PROG  = 1'b1
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/wlseq_order.sv
// Diagonal walker: yields (word-line, step) pairs in the interleaved program
// order. Step s of word-line w lives on diagonal d = w + s; diagonals rise,
// steps rise within a diagonal, and only in-range pairs are visited.
// Assumes init_nwl is 1..2**WL_W and advance is never raised with last high.
module wlseq_order #(
    parameter int WL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic [WL_W:0]   init_nwl,
    input  logic            init_three,
    input  logic            advance,
    output logic [WL_W-1:0] wl,
    output logic [1:0]      step,
    output logic            last
);
    localparam int DW = WL_W + 2;

    logic [DW-1:0] diag_q;
    logic [1:0]    stp_q;
    logic [1:0]    smax_q;
    logic [WL_W:0] nwl_q;
    logic [DW-1:0] nwl_ext;
    logic [DW-1:0] diag_nx;
    logic [DW-1:0] last_diag;
    logic [1:0]    lo_nx;
    logic [1:0]    hi_cur;

    assign nwl_ext = {1'b0, nwl_q};

    // Bounds of the step range on the current and next diagonal.
    always_comb begin
        diag_nx   = diag_q + 1'b1;
        lo_nx     = (diag_nx >= nwl_ext) ? 2'(diag_nx - nwl_ext + 1'b1) : 2'd0;
        hi_cur    = (diag_q < DW'(smax_q)) ? diag_q[1:0] : smax_q;
        last_diag = nwl_ext - 1'b1 + DW'(smax_q);
        last      = (diag_q == last_diag) && (stp_q == hi_cur);
        wl        = WL_W'(diag_q - DW'(stp_q));
        step      = stp_q;
    end

    // Position register: reset, restart on init, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_q <= '0;
            stp_q  <= '0;
            smax_q <= 2'd1;
            nwl_q  <= '0;
        end else if (init) begin
            diag_q <= '0;
            stp_q  <= '0;
            smax_q <= init_three ? 2'd2 : 2'd1;
            nwl_q  <= init_nwl;
        end else if (advance) begin
            if (stp_q < hi_cur) begin
                stp_q <= stp_q + 1'b1;
            end else begin
                diag_q <= diag_nx;
                stp_q  <= lo_nx;
            end
        end
    end
endmodule

// File: rtl/wlseq_timer.sv
// Down-counter for the array operation time. load puts load_val in the
// counter; expired is high while the count is zero. Assumes load_val is the
// wanted duration minus one.
module wlseq_timer #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wlseq_ctrl.sv
// Job control: idle, offer a command, wait out the array time, finish.
// An optional erase comes before the program stream. Assumes the walker
// reports last for the final program pair.
module wlseq_ctrl
    import wlseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cfg_ok,
    input  logic erase_first,
    input  logic cmd_ready,
    input  logic flash_busy,
    input  logic timer_expired,
    input  logic order_last,
    output logic cmd_valid,
    output logic erase_phase,
    output logic order_init,
    output logic order_advance,
    output logic timer_load,
    output logic done
);
    seq_state_t state_q;
    logic       erase_q;
    logic       last_q;
    logic       accept;

    // Handshake and side-effect strobes.
    always_comb begin
        cmd_valid     = (state_q == ST_ISSUE);
        accept        = cmd_valid && cmd_ready;
        order_init    = (state_q == ST_IDLE) && start && cfg_ok;
        order_advance = accept && !erase_q && !order_last;
        timer_load    = accept;
        done          = (state_q == ST_FIN);
        erase_phase   = erase_q;
    end

    // Sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            erase_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start && cfg_ok) begin
                    state_q <= ST_ISSUE;
                    erase_q <= erase_first;
                    last_q  <= 1'b0;
                end
                ST_ISSUE: if (cmd_ready) begin
                    state_q <= ST_WAIT;
                    last_q  <= !erase_q && order_last;
                    erase_q <= 1'b0;
                end
                ST_WAIT: if (timer_expired && !flash_busy) begin
                    state_q <= last_q ? ST_FIN : ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_wl_prog_seq.sv
// Top of the word-line program order sequencer. It ties the job controller,
// the diagonal walker and the operation timer together. Assumes
// PROG_CYCLES and ERASE_CYCLES are at least 1 and that configuration inputs
// are steady while start is sampled.
module nand_wl_prog_seq
    import wlseq_pkg::*;
#(
    parameter int MAX_WL       = 128,
    parameter int PROG_CYCLES  = 125000,
    parameter int ERASE_CYCLES = 375000,
    localparam int WL_W        = $clog2(MAX_WL),
    localparam int LONGEST     = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int CW          = $clog2(LONGEST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      bits_per_cell,
    input  logic [WL_W:0]   num_wordlines,
    input  logic            erase_first,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic            cmd_type,
    output logic [WL_W-1:0] wl_index,
    output logic [1:0]      step_index,
    input  logic            flash_busy,
    output logic            done
);
    logic            cfg_ok;
    logic            erase_phase;
    logic            order_init;
    logic            order_advance;
    logic            order_last;
    logic            timer_load;
    logic            timer_expired;
    logic [WL_W-1:0] ord_wl;
    logic [1:0]      ord_step;
    logic [CW-1:0]   load_val;

    // Legal job: at least one word-line, no more than the block holds.
    assign cfg_ok = (num_wordlines != '0) && (num_wordlines <= (WL_W+1)'(MAX_WL));

    // Operation time for the command being accepted.
    assign load_val = erase_phase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);

    // Command fields: erase targets the whole block, reported as word-line 0.
    always_comb begin
        cmd_type   = erase_phase ? CMD_ERASE : CMD_PROG;
        wl_index   = erase_phase ? '0 : ord_wl;
        step_index = erase_phase ? 2'd0 : ord_step;
    end

    wlseq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_ok        (cfg_ok),
        .erase_first   (erase_first),
        .cmd_ready     (cmd_ready),
        .flash_busy    (flash_busy),
        .timer_expired (timer_expired),
        .order_last    (order_last),
        .cmd_valid     (cmd_valid),
        .erase_phase   (erase_phase),
        .order_init    (order_init),
        .order_advance (order_advance),
        .timer_load    (timer_load),
        .done          (done)
    );

    wlseq_order #(.WL_W(WL_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (order_init),
        .init_nwl   (num_wordlines),
        .init_three (bits_per_cell == 2'd3),
        .advance    (order_advance),
        .wl         (ord_wl),
        .step       (ord_step),
        .last       (order_last)
    );

    wlseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (load_val),
        .expired  (timer_expired)
    );
endmodule

// File: rtl/nand_wl_prog_seq_chk.sv
// Port-level protocol checks for the sequencer, bound to every instance.
// Assumes nothing about cmd_ready, flash_busy or start beyond being 0/1.
module nand_wl_prog_seq_chk #(
    parameter int WL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            cmd_type,
    input logic [WL_W-1:0] wl_index,
    input logic [1:0]      step_index,
    input logic            flash_busy,
    input logic            done
);
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_type) && $stable(wl_index) && $stable(step_index)); // R6

    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid && !done); // R7

    AST_BUSY_HOLDS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(start) || !$past(flash_busy)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R9

    AST_ERASE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_type |-> wl_index == '0 && step_index == 2'd0); // R2

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> step_index <= 2'd2); // R4
endmodule

bind nand_wl_prog_seq nand_wl_prog_seq_chk #(.WL_W(WL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_type   (cmd_type),
    .wl_index   (wl_index),
    .step_index (step_index),
    .flash_busy (flash_busy),
    .done       (done)
);

// File: tb/sim_nand_wl_prog_seq.sv
module sim_nand_wl_prog_seq;
    localparam int MAX_WL = 16;
    localparam int PC     = 6;
    localparam int EC     = 11;
    localparam int WL_W   = 4;
    localparam int LIMIT  = 300;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      bits_per_cell = 2'd2;
    logic [WL_W:0]   num_wordlines = '0;
    logic            erase_first = 1'b0;
    logic            cmd_valid;
    logic            cmd_ready = 1'b0;
    logic            cmd_type;
    logic [WL_W-1:0] wl_index;
    logic [1:0]      step_index;
    logic            flash_busy = 1'b0;
    logic            done;

    int n_chk = 0;
    int n_bad = 0;
    int q_t[$];
    int q_w[$];
    int q_s[$];

    always #4 clk = ~clk;

    nand_wl_prog_seq #(.MAX_WL(MAX_WL), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bits_per_cell(bits_per_cell),
        .num_wordlines(num_wordlines), .erase_first(erase_first),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
        .wl_index(wl_index), .step_index(step_index), .flash_busy(flash_busy),
        .done(done)
    );

    function automatic int pack(int t, int w, int s);
        return t * 10000 + w * 10 + s;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected stream from the diagonal rule.
    task automatic build(int steps, int nwl, bit ers);
        q_t.delete(); q_w.delete(); q_s.delete();
        if (ers) begin q_t.push_back(0); q_w.push_back(0); q_s.push_back(0); end
        for (int d = 0; d <= nwl + steps - 2; d++) begin
            for (int s = 0; s < steps; s++) begin
                if (d - s >= 0 && d - s < nwl) begin
                    q_t.push_back(1); q_w.push_back(d - s); q_s.push_back(s);
                end
            end
        end
    endtask

    task automatic run_job(int bpc, int nwl, bit ers, int max_stall, int busy_max, bit poke, string req);
        int steps = (bpc == 3) ? 3 : 2;
        build(steps, nwl, ers);
        @(negedge clk);
        bits_per_cell = 2'(bpc); num_wordlines = (WL_W+1)'(nwl); erase_first = ers; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cmd_valid == 1'b1, "R2", "valid after start", int'(cmd_valid), 1);
        for (int i = 0; i < q_t.size(); i++) begin
            int exp_p = pack(q_t[i], q_w[i], q_s[i]);
            int stall = $urandom_range(0, max_stall);
            int k = (busy_max > 0) ? $urandom_range(0, busy_max) : 0;
            int t = (q_t[i] == 0) ? EC : PC;
            int gap = 0;
            int exp_gap;
            check(cmd_valid && pack(int'(cmd_type), int'(wl_index), int'(step_index)) == exp_p,
                  (i == 0) ? "R2" : req, "command", pack(int'(cmd_type), int'(wl_index), int'(step_index)), exp_p);
            for (int j = 0; j < stall; j++) begin
                cmd_ready = 1'b0;
                @(negedge clk);
                check(cmd_valid && pack(int'(cmd_type), int'(wl_index), int'(step_index)) == exp_p,
                      "R6", "stalled command", pack(int'(cmd_type), int'(wl_index), int'(step_index)), exp_p);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            while (!cmd_valid && !done && gap < LIMIT) begin
                flash_busy = (gap < k);
                start = poke && (i == 0) && (gap == 0);
                gap++;
                @(negedge clk);
            end
            flash_busy = 1'b0; start = 1'b0;
            exp_gap = (t > k + 1) ? t : k + 1;
            check(gap == exp_gap, (k == 0) ? "R7" : "R8", "wait cycles", gap, exp_gap);
            if (i == q_t.size() - 1) begin
                check(done && !cmd_valid, "R9", "done at end", int'(done), 1);
                @(negedge clk);
                check(!done && !cmd_valid, "R9", "done width", int'(done), 0);
            end else begin
                check(cmd_valid && !done, "R3", "next command present", int'(cmd_valid), 1);
            end
        end
    endtask

    task automatic bad_start(int nwl);
        @(negedge clk);
        num_wordlines = (WL_W+1)'(nwl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 4; j++) begin
            check(!cmd_valid && !done, "R10", "illegal start ignored", int'(cmd_valid), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5a));
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done, "R1", "in reset", int'(cmd_valid) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && !done, "R1", "after reset", int'(cmd_valid) + int'(done), 0);

        run_job(2, 4, 0, 0, 0, 0, "R3");
        run_job(3, 5, 1, 2, 0, 0, "R3");
        run_job(2, 1, 0, 1, 0, 0, "R5");
        run_job(3, 1, 1, 0, 0, 0, "R5");
        run_job(0, 3, 0, 0, 0, 0, "R4");
        run_job(1, 2, 0, 1, 0, 0, "R4");
        run_job(3, 16, 1, 3, 9, 0, "R3");
        run_job(3, 3, 0, 1, 0, 1, "R10");
        bad_start(0);
        bad_start(17);
        for (int r = 0; r < 10; r++) begin
            int b = ($urandom_range(0, 1) == 1) ? 3 : 2;
            run_job(b, $urandom_range(1, MAX_WL), 1'($urandom_range(0, 1)), 3, 9, 0, (b == 3) ? "R4" : "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule